// File: doc/BRIEF.md
# Single-Step Bidirectional Word Shifter

This block moves an n-bit word by at most one bit position in a single combinational pass. A two-bit mode input chooses one of four outcomes: the word passes through untouched, every bit moves one place toward the least significant end, every bit moves one place toward the most significant end, or the result is forced to zero. Because nothing is stored, a register-to-register shift through this block costs one clock cycle of the surrounding datapath rather than one cycle per bit position.

Two fill inputs supply the bit that enters the vacated position: one for the top bit on a move toward the LSB, one for the bottom bit on a move toward the MSB. Two spill outputs expose the bits that leave the word in each direction, so several shifters can be chained into a wider one or an external flag can capture the lost bit.

Top module: `bidir_shift_unit`

## Requirements
- R1: With mode 2'b00 the output word equals the input word bit for bit.
- R2: With mode 2'b01 output bit i equals input bit i+1 for every i below the top bit, and the top output bit equals the `fill_msb` input.
- R3: With mode 2'b10 output bit i equals input bit i-1 for every i above bit 0, and output bit 0 equals the `fill_lsb` input.
- R4: With mode 2'b11 the output word is all zeros, whatever the input word and fill bits.
- R5: `spill_high` always equals the top bit of the input word, in every mode.
- R6: `spill_low` always equals bit 0 of the input word, in every mode.
- R7: The fill inputs have no effect on the output word in modes 2'b00 and 2'b11; `fill_lsb` has no effect in mode 2'b01 and `fill_msb` has none in mode 2'b10.
- R8: The block holds no state: a change on any input is reflected at the outputs without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| word_in | input | W | Word to be passed or shifted |
| mode | input | 2 | 00 pass, 01 toward LSB, 10 toward MSB, 11 clear |
| fill_msb | input | 1 | Bit entering the top position on a move toward the LSB |
| fill_lsb | input | 1 | Bit entering bit 0 on a move toward the MSB |
| word_out | output | W | Resulting word |
| spill_high | output | 1 | Top bit of the input word |
| spill_low | output | 1 | Bit 0 of the input word |

## Verification
The block has no internal state, so any fault in the mode decode or in one bit slice shows at `word_out` in the very cycle the offending mode and data pattern are applied; there is nothing that can hide and surface later. A miswired neighbour link appears only for input words where the two neighbouring bits differ, and a fill bit wired to the wrong end appears only when that fill differs from the bit it displaced, which is why every word of a small configuration is applied with all four fill combinations in every mode.

// File: rtl/shift_unit_pkg.sv
package shift_unit_pkg;

    // Mode encoding seen on the mode port.
    typedef enum logic [1:0] {
        SHM_PASS  = 2'b00,
        SHM_DOWN  = 2'b01,
        SHM_UP    = 2'b10,
        SHM_CLEAR = 2'b11
    } shift_mode_e;

    // Per-slice source choice: at most one leg is active.
    typedef struct packed {
        logic take_self;
        logic take_above;
        logic take_below;
    } slice_pick_t;

    function automatic slice_pick_t pick_for_mode(input shift_mode_e m);
        slice_pick_t p;
        p = '0;
        unique case (m)
            SHM_PASS:  p.take_self  = 1'b1;
            SHM_DOWN:  p.take_above = 1'b1;
            SHM_UP:    p.take_below = 1'b1;
            default:   p = '0;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/shift_mode_decode.sv
module shift_mode_decode
    import shift_unit_pkg::*;
(
    input  logic [1:0]  mode,
    output slice_pick_t pick
);
    shift_mode_e mode_e;

    always_comb begin
        mode_e = shift_mode_e'(mode);
        pick   = pick_for_mode(mode_e);
    end
endmodule

// File: rtl/shift_bit_slice.sv
module shift_bit_slice
    import shift_unit_pkg::*;
(
    input  slice_pick_t pick,
    input  logic        own_bit,
    input  logic        above_bit,
    input  logic        below_bit,
    output logic        out_bit
);
    // AND-OR three-way select; an all-zero pick yields zero.
    always_comb begin
        out_bit = (pick.take_self  & own_bit)
                | (pick.take_above & above_bit)
                | (pick.take_below & below_bit);
    end
endmodule

// File: rtl/shift_edge_taps.sv
module shift_edge_taps #(
    parameter int W = 16
) (
    input  logic [W-1:0] word_in,
    output logic         spill_high,
    output logic         spill_low
);
    localparam int TOP = W - 1;

    always_comb begin
        spill_high = word_in[TOP];
        spill_low  = word_in[0];
    end
endmodule

// File: rtl/bidir_shift_unit.sv
module bidir_shift_unit
    import shift_unit_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] word_in,
    input  logic [1:0]   mode,
    input  logic         fill_msb,
    input  logic         fill_lsb,
    output logic [W-1:0] word_out,
    output logic         spill_high,
    output logic         spill_low
);
    localparam int TOP = W - 1;

    slice_pick_t pick;

    shift_mode_decode u_decode (
        .mode (mode),
        .pick (pick)
    );

    for (genvar i = 0; i < W; i++) begin : g_slice
        logic above_src;
        logic below_src;

        if (i == TOP) begin : g_top
            assign above_src = fill_msb;
        end else begin : g_mid_a
            assign above_src = word_in[i+1];
        end

        if (i == 0) begin : g_bot
            assign below_src = fill_lsb;
        end else begin : g_mid_b
            assign below_src = word_in[i-1];
        end

        shift_bit_slice u_slice (
            .pick      (pick),
            .own_bit   (word_in[i]),
            .above_bit (above_src),
            .below_bit (below_src),
            .out_bit   (word_out[i])
        );
    end

    shift_edge_taps #(.W(W)) u_taps (
        .word_in    (word_in),
        .spill_high (spill_high),
        .spill_low  (spill_low)
    );
endmodule

// File: rtl/shift_unit_checker.sv
module shift_unit_checker #(
    parameter int W = 16
) (
    input logic [W-1:0] word_in,
    input logic [1:0]   mode,
    input logic         fill_msb,
    input logic         fill_lsb,
    input logic [W-1:0] word_out,
    input logic         spill_high,
    input logic         spill_low
);
    localparam int TOP = W - 1;

    always_comb begin
        if (mode == 2'b00) begin
            // R1
            mode_pass_chk: assert (word_out == word_in);
        end
        if (mode == 2'b01) begin
            // R2
            mode_down_chk: assert (word_out[TOP-1:0] == word_in[TOP:1]
                                   && word_out[TOP] == fill_msb);
        end
        if (mode == 2'b10) begin
            // R3
            mode_up_chk: assert (word_out[TOP:1] == word_in[TOP-1:0]
                                 && word_out[0] == fill_lsb);
        end
        if (mode == 2'b11) begin
            // R4
            mode_clear_chk: assert (word_out == '0);
        end
        // R5
        spill_high_chk: assert (spill_high == word_in[TOP]);
        // R6
        spill_low_chk: assert (spill_low == word_in[0]);
    end
endmodule

bind bidir_shift_unit shift_unit_checker #(.W(W)) u_chk (
    .word_in    (word_in),
    .mode       (mode),
    .fill_msb   (fill_msb),
    .fill_lsb   (fill_lsb),
    .word_out   (word_out),
    .spill_high (spill_high),
    .spill_low  (spill_low)
);

// File: tb/bidir_shift_unit_test.sv
`timescale 1ns/1ps
module bidir_shift_unit_test;
    localparam int W = 8;
    localparam int WORDS = 1 << W;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] word_in = '0;
    logic [1:0]   mode = 2'b00;
    logic         fill_msb = 1'b0;
    logic         fill_lsb = 1'b0;
    logic [W-1:0] word_out;
    logic         spill_high;
    logic         spill_low;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    bidir_shift_unit #(.W(W)) uut (
        .word_in    (word_in),
        .mode       (mode),
        .fill_msb   (fill_msb),
        .fill_lsb   (fill_lsb),
        .word_out   (word_out),
        .spill_high (spill_high),
        .spill_low  (spill_low)
    );

    function automatic logic [W-1:0] model(input logic [W-1:0] w, input logic [1:0] m,
                                           input logic fm, input logic fl);
        int v;
        int full;
        full = WORDS - 1;
        case (m)
            2'b00:   v = int'(w);
            2'b01:   v = (int'(w) / 2) + (fm ? WORDS / 2 : 0);
            2'b10:   v = ((int'(w) * 2) % WORDS) + (fl ? 1 : 0);
            default: v = 0;
        endcase
        return W'(v & full);
    endfunction

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h (word %h mode %b fm %b fl %b)",
                     req, act, exp, word_in, mode, fill_msb, fill_lsb);
        end
    endtask

    function automatic string req_for(input logic [1:0] m, input logic fm, input logic fl);
        if ((m == 2'b00 || m == 2'b11) && (fm || fl)) return "R7";
        if (m == 2'b01 && fl) return "R7";
        if (m == 2'b10 && fm) return "R7";
        case (m)
            2'b00:   return "R1";
            2'b01:   return "R2";
            2'b10:   return "R3";
            default: return "R4";
        endcase
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        // Initial state: zero word, pass mode gives zero out.
        check("R1", word_out, '0);

        for (int m = 0; m < 4; m++) begin
            for (int f = 0; f < 4; f++) begin
                for (int w = 0; w < WORDS; w++) begin
                    @(posedge clk);
                    word_in  = W'(w);
                    mode     = 2'(m);
                    fill_msb = f[1];
                    fill_lsb = f[0];
                    @(negedge clk);
                    check(req_for(mode, fill_msb, fill_lsb), word_out,
                          model(word_in, mode, fill_msb, fill_lsb));
                    check("R5", W'(spill_high), W'(word_in[W-1]));
                    check("R6", W'(spill_low), W'(word_in[0]));
                end
            end
        end

        // R7: toggling the irrelevant fill leaves the word unchanged.
        @(posedge clk);
        word_in = 8'hA5; mode = 2'b01; fill_lsb = 1'b0; fill_msb = 1'b1;
        #0.5;
        fill_lsb = 1'b1;
        #0.5;
        check("R7", word_out, 8'hD2);
        mode = 2'b10; fill_msb = 1'b0;
        #0.5;
        check("R7", word_out, 8'h4B);

        // R8: output follows an input change between clock edges.
        @(negedge clk);
        word_in = 8'h3C; mode = 2'b00;
        #0.5;
        check("R8", word_out, 8'h3C);
        word_in = 8'h81; mode = 2'b10; fill_lsb = 1'b0;
        #0.5;
        check("R8", word_out, 8'h02);
        check("R8", W'(spill_high), W'(1));

        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 150000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected done");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule